// File: doc/BRIEF.md
# Bit-band alias access bridge

This bridge sits between a bus master and a byte-addressable memory port. Two address windows, each 32 MiB long, are treated as alias spaces. Every 32-bit word inside an alias window stands for one bit of a backing region. An alias read hands back 0 or 1. An alias write sets or clears that single bit through a read of the containing unit followed by a write-back. The master uses a request/ready port that carries an address, a size code, write data and read data. The block drives the memory side as a sequencer with a matching request/ready port.

The low 25 address bits of an alias access form the alias offset. The target byte is the region base ORed with the offset shifted right by five, so eight alias words cover one target byte. The access size picks the unit that is fetched: a byte, an even-aligned halfword or a four-byte-aligned word. It also picks how many bits of the offset, taken above its two lowest bits, form the bit number. Any address outside both windows is forwarded to memory unchanged as one phase. It completes with the same latency as an alias read. The memory port is little-endian: bit 0 of a unit is bit 0 of its lowest-addressed byte.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `m_ready` and `mem_req` are both 0.
- R2: An address in 0x2200_0000..0x23FF_FFFF is an alias of the region at 0x2000_0000, and an address in 0x4200_0000..0x43FF_FFFF is an alias of the region at 0x4000_0000. The target address is base | (addr[24:0] >> 5), and it is driven on `mem_addr` for every memory phase of that access.
- R3: Size code 0 (byte) gives the bit number addr[4:2], and the target address is used without alignment.
- R4: Size code 1 (halfword) clears bit 0 of the target address and gives the bit number addr[5:2]. Size code 2 (word) clears bits 1:0 of the target address and gives the bit number addr[6:2]. Code 3 is handled like code 2. `mem_size` carries the master's size code.
- R5: An alias read makes exactly one memory read (`mem_we` = 0). `m_rdata` is 1 when the selected bit of the returned unit is set and 0 otherwise, and bits 31:1 of `m_rdata` are 0.
- R6: An alias write makes one memory read and then one memory write to the same address and size. The data written is the unit just read, with the selected bit equal to `m_wdata[0]`. `m_wdata[31:1]` has no effect.
- R7: An access outside both windows makes one memory phase. That phase carries the master's address, size, write enable and write data unchanged, and for a read the memory data is returned unchanged on `m_rdata`.
- R8: `mem_req` rises in the cycle after a request is accepted. It stays high, with its address, size and write enable stable, until `mem_ready` is seen. No new master request is taken until the block is idle again.
- R9: `m_ready` is a one-cycle pulse in the cycle right after the final memory handshake of the access. `m_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until `m_ready` |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master byte address |
| m_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Access complete, one-cycle pulse |
| m_rdata | output | 32 | Read result, valid with `m_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Memory unit size code |
| mem_wdata | output | 32 | Memory write data, unit in the low bits |
| mem_ready | input | 1 | Memory handshake complete; read data valid |
| mem_rdata | input | 32 | Memory read data, unit in the low bits, little-endian |

## Verification
The assertions assume a master that keeps `m_req` and its fields steady until `m_ready` and drops the request in the cycle `m_ready` is seen. They also assume a memory that raises `mem_ready` for only one cycle per handshake and returns read data with zeros above the unit. The bench's master task follows this rule. It drives fields only at falling edges and lowers `m_req` as soon as it sees the pulse. Its memory model answers after a chosen latency of 0 to 3 cycles and clears `mem_ready` at the next falling edge. Stimulus covers both windows, every size code, the last word of a window and the addresses just outside each window. A run of mixed reads and writes also hits a few overlapping target bytes.

// File: rtl/bb_pkg.sv
package bb_pkg;

  // Size codes carried on m_size / mem_size
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Sequencer states (order matches the progression of an alias write)
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_DONE
  } bb_state_e;

endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFS_BITS = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             size,
  output logic                   hit,
  output logic [AW-1:0]          tgt_addr,
  output logic [$clog2(DW)-1:0]  bit_idx
);
  localparam int IDX_W   = $clog2(DW);
  localparam int WORD_SH = 2;            // alias words are 4 bytes
  localparam int BIT_SH  = WORD_SH + 3;  // 8 alias words per target byte
  localparam logic [AW-1:0] OFS_MASK = {{(AW-OFS_BITS){1'b0}}, {OFS_BITS{1'b1}}};

  // Force the target to the alignment of the unit being fetched
  function automatic logic [AW-1:0] align_unit(input logic [AW-1:0] a, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return a;
      SZ_HALF: return a & ~AW'(1);
      default: return a & ~AW'(DW/8 - 1);
    endcase
  endfunction

  // Bit number inside the unit, counted from the low byte
  function automatic logic [IDX_W-1:0] bit_index(input logic [AW-1:0] a, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return IDX_W'(a >> WORD_SH) & IDX_W'(7);
      SZ_HALF: return IDX_W'(a >> WORD_SH) & IDX_W'(15);
      default: return IDX_W'(a >> WORD_SH);
    endcase
  endfunction

  logic [NUM_WIN-1:0] win_hit;
  logic [AW-1:0]      win_tgt [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [AW-1:0] ALIAS_B  = ALIAS_BASES[w*AW +: AW];
    localparam logic [AW-1:0] REGION_B = REGION_BASES[w*AW +: AW];
    assign win_hit[w] = (addr & ~OFS_MASK) == (ALIAS_B & ~OFS_MASK);
    assign win_tgt[w] = align_unit(REGION_B | ((addr & OFS_MASK) >> BIT_SH), size);
  end

  // Lowest-numbered window wins if windows were ever made to overlap
  always_comb begin
    hit      = 1'b0;
    tgt_addr = addr;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        hit      = 1'b1;
        tgt_addr = win_tgt[w];
      end
    end
  end

  assign bit_idx = bit_index(addr, size);

endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
  import bb_pkg::*;
#(
  parameter int DW = 32,
  parameter int IDX_W = $clog2(DW)
) (
  input  logic [DW-1:0]    raw,
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] idx,
  input  logic             set_val,
  output logic [DW-1:0]    unit,
  output logic             bit_val,
  output logic [DW-1:0]    merged
);
  function automatic logic [DW-1:0] unit_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return DW'(8'hFF);
      SZ_HALF: return DW'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  logic [DW-1:0] sel;

  assign unit    = raw & unit_mask(size);
  assign sel     = {{(DW-1){1'b0}}, 1'b1} << idx;
  assign bit_val = |(unit & sel);
  assign merged  = set_val ? (unit | sel) : (unit & ~sel);

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic m_req,
  input  logic rmw,
  input  logic mem_ready,
  output logic accept,
  output logic rd_phase,
  output logic wr_phase,
  output logic rd_hs,
  output logic done,
  output logic mem_req
);
  bb_state_e st, nxt;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:              if (m_req) nxt = ST_RD_REQ;
      ST_RD_REQ, ST_RD_WAIT: nxt = mem_ready ? (rmw ? ST_WR_REQ : ST_DONE) : ST_RD_WAIT;
      ST_WR_REQ, ST_WR_WAIT: nxt = mem_ready ? ST_DONE : ST_WR_WAIT;
      ST_DONE:              nxt = ST_IDLE;
      default:              nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  // Named events for the datapath and the assertions
  assign accept   = (st == ST_IDLE) && m_req;
  assign rd_phase = (st == ST_RD_REQ) || (st == ST_RD_WAIT);
  assign wr_phase = (st == ST_WR_REQ) || (st == ST_WR_WAIT);
  assign rd_hs    = rd_phase && mem_ready;
  assign done     = (st == ST_DONE);
  assign mem_req  = rd_phase || wr_phase;

  // R8: a memory request is held until it is answered
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req);

  // R8: an accepted request leads to a memory request in the next cycle
  a_r8_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req);

  // R9: completion follows a memory handshake and lasts one cycle
  a_r9_done_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ready));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a read-modify-write moves straight from the read answer into the write
  a_r6_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hs && rmw |=> wr_phase);

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFS_BITS = 25,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN*AW-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [1:0]    m_size,
  input  logic [DW-1:0] m_wdata,
  output logic          m_ready,
  output logic [DW-1:0] m_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(DW);

  // Decode of the live master request
  logic             dec_hit;
  logic [AW-1:0]    dec_tgt;
  logic [IDX_W-1:0] dec_idx;

  bb_decode #(
    .AW(AW), .DW(DW), .OFS_BITS(OFS_BITS), .NUM_WIN(NUM_WIN),
    .ALIAS_BASES(ALIAS_BASES), .REGION_BASES(REGION_BASES)
  ) u_decode (
    .addr(m_addr), .size(m_size),
    .hit(dec_hit), .tgt_addr(dec_tgt), .bit_idx(dec_idx)
  );

  // Sequencer
  logic accept, rd_phase, wr_phase, rd_hs, done;
  logic lat_alias, lat_we;

  bb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .m_req(m_req),
    .rmw(lat_alias && lat_we), .mem_ready(mem_ready),
    .accept(accept), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .rd_hs(rd_hs), .done(done), .mem_req(mem_req)
  );

  // Request held for the whole access
  logic [AW-1:0]    lat_addr, lat_tgt;
  logic [1:0]       lat_size;
  logic [DW-1:0]    lat_wdata;
  logic [IDX_W-1:0] lat_idx;
  logic [DW-1:0]    cap_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_alias <= 1'b0;
      lat_we    <= 1'b0;
      lat_addr  <= '0;
      lat_tgt   <= '0;
      lat_size  <= SZ_BYTE;
      lat_wdata <= '0;
      lat_idx   <= '0;
    end else if (accept) begin
      lat_alias <= dec_hit;
      lat_we    <= m_we;
      lat_addr  <= m_addr;
      lat_tgt   <= dec_tgt;
      lat_size  <= m_size;
      lat_wdata <= m_wdata;
      lat_idx   <= dec_idx;
    end
  end

  // Unit returned by the read phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_raw <= '0;
    else if (rd_hs) cap_raw <= mem_rdata;
  end

  logic [DW-1:0] cap_unit, merged;
  logic          cap_bit;

  bb_bitop #(.DW(DW), .IDX_W(IDX_W)) u_bitop (
    .raw(cap_raw), .size(lat_size), .idx(lat_idx), .set_val(lat_wdata[0]),
    .unit(cap_unit), .bit_val(cap_bit), .merged(merged)
  );

  // Memory side
  assign mem_we    = wr_phase || (rd_phase && !lat_alias && lat_we);
  assign mem_addr  = lat_alias ? lat_tgt : lat_addr;
  assign mem_size  = lat_size;
  assign mem_wdata = wr_phase ? merged : lat_wdata;

  // Master side
  assign m_ready = done;
  assign m_rdata = lat_alias ? {{(DW-1){1'b0}}, cap_bit} : cap_raw;

  // R8: the memory request fields do not move while waiting
  a_r8_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  // R6: the write-back differs from the unit read in at most one bit
  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && lat_alias |-> $countones(mem_wdata ^ cap_unit) <= 1);

  // R6: the written bit follows bit 0 of the master's data
  a_r6_bit_from_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase && lat_alias |-> mem_wdata[lat_idx] == lat_wdata[0]);

  // R5: an alias result carries nothing above bit 0
  a_r5_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready && lat_alias |-> (m_rdata >> 1) == '0);

  // R1: nothing is driven in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !m_ready && !mem_req);

endmodule

// File: tb/test_bitband_bridge.sv
module test_bitband_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic        m_ready;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  always #5 clk = ~clk;

  bitband_bridge i_bitband_bridge (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural memory: sparse bytes over a deterministic fill
  logic [7:0] mem_bytes [bit [31:0]];

  function automatic logic [7:0] peek(input logic [31:0] a);
    if (mem_bytes.exists(a)) return mem_bytes[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] unit_at(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < nb(sz); i++) v = v | (32'(peek(a + i)) << (8 * i));
    return v;
  endfunction

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [1:0]  sz;
    logic [31:0] wd;
  } txn_t;

  txn_t q[$];

  // One master access, checked against the expected memory traffic on every cycle
  task automatic access(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int lat, input string tag);
    logic [31:0] base, off, tgt, unit, exp_rd;
    int bitn, cyc, wcnt;
    bit al, fin, just, rs;
    txn_t t;
    al = 1'b0; base = 32'h0; off = 32'h0; bitn = 0;
    if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin
      al = 1'b1; base = 32'h2000_0000; off = a - 32'h2200_0000;
    end else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin
      al = 1'b1; base = 32'h4000_0000; off = a - 32'h4200_0000;
    end
    if (al) begin
      tgt  = base + off / 32;
      tgt  = tgt - tgt % nb(sz);
      bitn = int'((off / 4) % (8 * nb(sz)));
      unit = unit_at(tgt, sz);
      exp_rd = (unit >> bitn) & 32'h1;
      q.push_back('{tgt, 1'b0, sz, 32'h0});
      if (we) begin
        if (wd[0]) unit = unit | (32'h1 << bitn);
        else       unit = unit & ~(32'h1 << bitn);
        q.push_back('{tgt, 1'b1, sz, unit});
      end
    end else begin
      exp_rd = unit_at(a, sz);
      q.push_back('{a, we, sz, wd});
    end

    @(negedge clk);
    chk(!mem_req && !m_ready, {tag, " R8 idle between accesses"}, {30'h0, mem_req, m_ready}, 32'h0);
    m_req = 1'b1; m_we = we; m_addr = a; m_size = sz; m_wdata = wd;

    cyc = 0; wcnt = 0; fin = 1'b0; just = 1'b0; rs = 1'b0;
    while (!fin && cyc < 64) begin
      @(negedge clk);
      cyc++;
      just = rs; rs = 1'b0;
      if (mem_ready) begin mem_ready = 1'b0; mem_rdata = 32'h0; end
      if (m_ready) begin
        chk(q.size() == 0 && just, {tag, " R9 ready right after last memory handshake"},
            32'(q.size()), 32'h0);
        chk(!mem_req, {tag, " R8 request dropped at completion"}, {31'h0, mem_req}, 32'h0);
        if (!we) chk(m_rdata == exp_rd, {tag, " read result"}, m_rdata, exp_rd);
        m_req = 1'b0;
        fin = 1'b1;
      end else if (mem_req) begin
        if (q.size() == 0) begin
          chk(1'b0, {tag, " R8 unexpected memory request"}, mem_addr, 32'h0);
          m_req = 1'b0;
          fin = 1'b1;
        end else begin
          t = q[0];
          if (wcnt == 0) begin
            chk(mem_addr == t.addr, {tag, " memory address"}, mem_addr, t.addr);
            chk(mem_we == t.we, {tag, " memory write enable"}, {31'h0, mem_we}, {31'h0, t.we});
            chk(mem_size == t.sz, {tag, " R4 memory size"}, {30'h0, mem_size}, {30'h0, t.sz});
            if (t.we) chk(mem_wdata == t.wd, {tag, " memory write data"}, mem_wdata, t.wd);
          end
          if (wcnt == lat) begin
            if (mem_we) begin
              for (int i = 0; i < nb(mem_size); i++) mem_bytes[mem_addr + i] = mem_wdata[8*i +: 8];
            end else begin
              mem_rdata = unit_at(mem_addr, mem_size);
            end
            mem_ready = 1'b1;
            void'(q.pop_front());
            rs = 1'b1;
            wcnt = 0;
          end else begin
            wcnt++;
          end
        end
      end else begin
        chk(1'b0, {tag, " R8 memory request missing while access pending"}, 32'h0, 32'h1);
      end
    end
    if (!fin) begin
      chk(1'b0, {tag, " access watchdog"}, 32'(cyc), 32'd64);
      m_req = 1'b0;
      q.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL run watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    m_req = 1'b0; m_we = 1'b0; m_addr = 32'h0; m_size = 2'd0; m_wdata = 32'h0;
    mem_ready = 1'b0; mem_rdata = 32'h0;
    repeat (3) @(negedge clk);
    chk(!m_ready && !mem_req, "R1 outputs during reset", {30'h0, m_ready, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_ready && !mem_req, "R1 outputs after reset release", {30'h0, m_ready, mem_req}, 32'h0);

    // Byte alias reads, first window
    access(1'b0, 32'h2200_0000, 2'd0, 32'h0, 0, "R2 R3 R5 byte bit0 window0");
    access(1'b0, 32'h2200_001C, 2'd0, 32'h0, 1, "R3 R5 byte bit7");
    access(1'b0, 32'h2200_0020, 2'd0, 32'h0, 2, "R2 R3 next target byte");
    access(1'b0, 32'h23FF_FFFC, 2'd0, 32'h0, 0, "R2 R3 last alias word of window0");
    // Second window
    access(1'b0, 32'h4200_0104, 2'd0, 32'h0, 2, "R2 R5 byte window1");
    access(1'b0, 32'h43FF_FFF8, 2'd2, 32'h0, 1, "R2 R4 word at top of window1");
    // Halfword and word alignment
    access(1'b0, 32'h2200_0078, 2'd1, 32'h0, 0, "R4 R5 halfword bit14 aligned down");
    access(1'b0, 32'h2200_00FC, 2'd2, 32'h0, 3, "R4 R5 word bit31 aligned down");
    access(1'b0, 32'h2200_0040, 2'd3, 32'h0, 1, "R4 size code 3 as word");

    // Alias writes with junk in the upper data bits
    access(1'b1, 32'h2200_0014, 2'd0, 32'hFFFF_FFFF, 0, "R6 set bit5");
    access(1'b0, 32'h2000_0000, 2'd0, 32'h0, 0, "R6 R7 readback after set");
    access(1'b0, 32'h2200_0014, 2'd0, 32'h0, 1, "R6 alias readback after set");
    access(1'b1, 32'h2200_0014, 2'd0, 32'hFFFF_FFFE, 2, "R6 clear bit5 upper data ignored");
    access(1'b0, 32'h2200_0014, 2'd0, 32'h0, 0, "R6 alias readback after clear");
    access(1'b1, 32'h4200_0178, 2'd1, 32'h0000_0001, 3, "R6 R4 halfword set window1");
    access(1'b1, 32'h2200_00E0, 2'd2, 32'h1234_5670, 1, "R6 R4 word clear bit24");

    // Pass-through traffic around the windows
    access(1'b1, 32'h2400_0000, 2'd2, 32'hDEAD_BEEF, 1, "R7 write above window0");
    access(1'b0, 32'h2400_0000, 2'd2, 32'h0, 0, "R7 read back above window0");
    access(1'b0, 32'h21FF_FFFC, 2'd2, 32'h0, 2, "R7 word below window0");
    access(1'b0, 32'h41FF_FFFE, 2'd1, 32'h0, 0, "R7 halfword below window1");
    access(1'b1, 32'h4400_0003, 2'd0, 32'hFFFF_FF3C, 3, "R7 byte write above window1");
    access(1'b0, 32'h4400_0003, 2'd0, 32'h0, 1, "R7 byte read above window1");

    // Mixed alias traffic over a few overlapping target bytes
    r = 32'hACE1_1357;
    for (int k = 0; k < 28; k++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      access(r[12], (r[3] ? 32'h4200_0000 : 32'h2200_0000) + (r & 32'h0000_00FC),
             2'(int'(r[11:10]) % 3), r ^ 32'h5555_0000, int'(r[14:13]) % 4,
             r[12] ? "R6 R9 mixed alias write" : "R5 R8 mixed alias read");
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule